// File: doc/BRIEF.md
# Sized Load Address and Extract Unit

This block carries out the load instructions of a 32-bit core. It is handed the raw instruction word, the value of the base register and the value of the offset register. From the opcode it works out the access size and whether the offset comes from the instruction or from a register. For the immediate forms it puts the split immediate back together, sign-extends it and scales it by the access size. It then adds the offset to the base to get the effective byte address.

A legal, aligned load issues one word read on a simple request/valid memory port. The block picks the addressed byte lane or halfword out of the returned little-endian word and zero-extends it. It then returns the 32-bit result with a one-cycle done pulse. Two cases raise a one-cycle fault pulse instead: a misaligned word or halfword address, where no read is issued, and a memory error response. The base register is never updated, and only one load is in flight at a time.

Top module: `sized_load_unit`

## Requirements
- R1: Opcode field bits 6:0 select the load kind. 0x01 is a word load and 0x04 a register-offset word load. 0x02 and 0x05 are the halfword loads. 0x03 and 0x06 are the byte loads. The first three of these use the immediate offset and the last three the register offset.
- R2: For immediate forms, a 15-bit offset is formed with instruction bits 31:21 as its upper eleven bits and bits 10:7 as its lower four. It is sign-extended, then shifted left by 2 for word, 1 for halfword and 0 for byte, and added to the base value. The offset register value has no effect on these forms.
- R3: For register-offset forms the effective address is the base value plus the offset register value. Instruction bits 10:7 and 31:26 have no effect.
- R4: One cycle after an accepted start, mem_req is high for exactly one cycle with mem_addr equal to the effective byte address. mem_addr holds that value until the load completes.
- R5: A word load returns the read data unchanged.
- R6: A halfword load returns read data bits 15:0 when address bit 1 is 0 and bits 31:16 when it is 1, zero-extended.
- R7: A byte load returns the byte lane selected by address bits 1:0 (lane 0 = bits 7:0), zero-extended. Byte loads never fault on alignment.
- R8: done is high for exactly the one cycle after mem_valid is seen without mem_err. result carries the loaded value in that cycle and keeps it afterwards.
- R9: When mem_valid comes with mem_err high, fault pulses in the next cycle and done stays low.
- R10: A word load whose address has bits 1:0 not zero, or a halfword load whose address has bit 0 set, pulses fault in the cycle after start and issues no mem_req.
- R11: A start with an opcode outside R1, or a start while a load is in flight, is ignored. It causes no request, no done and no fault, and it does not change mem_addr.
- R12: During and right after reset, mem_req, busy, done and fault are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a load with the inputs below |
| instr | input | 32 | Raw load instruction word |
| base_val | input | 32 | Base register value |
| offs_val | input | 32 | Offset register value (register forms) |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Effective byte address of the read |
| mem_valid | input | 1 | Read response present |
| mem_err | input | 1 | Read response is an error |
| mem_rdata | input | 32 | Read word |
| busy | output | 1 | A load is in flight |
| done | output | 1 | Load finished, result valid |
| result | output | 32 | Loaded value, zero-extended |
| fault | output | 1 | Memory fault pulse |

## Verification
mem_req and mem_addr are due in the first cycle after the start edge. A misalignment fault is due in that same cycle. done or fault from a response is due in the first cycle after the mem_valid edge. The bench drives inputs on the falling edge and samples in that same half-cycle, just after each of those edges. It checks the request in the cycle after start, holds mem_valid back for zero to two further cycles, and then checks done, fault and result in the single cycle after the response. It also checks the cycle after that, to confirm the pulse has ended and the result has held.

// File: rtl/sized_load_pkg.sv
// Shared constants and types for the sized load unit.
// Assumes a 32-bit instruction with a 7-bit opcode in bits 6:0.
package sized_load_pkg;

    localparam int INSTR_W = 32;
    localparam int OP_W    = 7;
    localparam int IMM_W   = 15;
    localparam int IMM_LO_W = 4;
    localparam int IMM_HI_W = IMM_W - IMM_LO_W;

    localparam logic [OP_W-1:0] OP_LD_WORD_IMM = 7'h01;
    localparam logic [OP_W-1:0] OP_LD_HALF_IMM = 7'h02;
    localparam logic [OP_W-1:0] OP_LD_BYTE_IMM = 7'h03;
    localparam logic [OP_W-1:0] OP_LD_WORD_REG = 7'h04;
    localparam logic [OP_W-1:0] OP_LD_HALF_REG = 7'h05;
    localparam logic [OP_W-1:0] OP_LD_BYTE_REG = 7'h06;

    // Encoded as log2 of the access size in bytes, so it is also the shift.
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef struct packed {
        logic      legal;
        logic      use_imm;
        acc_size_e size;
    } ld_ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } ld_state_e;

endpackage

// File: rtl/sized_load_decode.sv
// Opcode decode and immediate rebuild for load instructions.
// Purely combinational. Assumes the caller has sliced the instruction fields.
module sized_load_decode
    import sized_load_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [OP_W-1:0]     opcode,
    input  logic [IMM_HI_W-1:0] imm_hi,
    input  logic [IMM_LO_W-1:0] imm_lo,
    output ld_ctrl_t            ctrl,
    output logic [XLEN-1:0]     imm_off
);

    logic [IMM_W-1:0] imm_raw;
    logic [XLEN-1:0]  imm_sext;

    // Map the opcode onto legality, offset source and access size.
    always_comb begin
        ctrl = '{legal: 1'b0, use_imm: 1'b0, size: SZ_WORD};
        case (opcode)
            OP_LD_WORD_IMM: ctrl = '{legal: 1'b1, use_imm: 1'b1, size: SZ_WORD};
            OP_LD_HALF_IMM: ctrl = '{legal: 1'b1, use_imm: 1'b1, size: SZ_HALF};
            OP_LD_BYTE_IMM: ctrl = '{legal: 1'b1, use_imm: 1'b1, size: SZ_BYTE};
            OP_LD_WORD_REG: ctrl = '{legal: 1'b1, use_imm: 1'b0, size: SZ_WORD};
            OP_LD_HALF_REG: ctrl = '{legal: 1'b1, use_imm: 1'b0, size: SZ_HALF};
            OP_LD_BYTE_REG: ctrl = '{legal: 1'b1, use_imm: 1'b0, size: SZ_BYTE};
            default:        ctrl = '{legal: 1'b0, use_imm: 1'b0, size: SZ_WORD};
        endcase
    end

    // Join the two immediate pieces and sign-extend to the data width.
    always_comb begin
        imm_raw  = {imm_hi, imm_lo};
        imm_sext = {{(XLEN-IMM_W){imm_raw[IMM_W-1]}}, imm_raw};
    end

    // Scale the offset by the access size.
    always_comb begin
        imm_off = imm_sext << ctrl.size;
    end

endmodule

// File: rtl/sized_load_agen.sv
// Effective address generation and alignment check.
// Combinational. Assumes byte addressing with a 4-byte memory word.
module sized_load_agen
    import sized_load_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] base_val,
    input  logic [XLEN-1:0] offs_val,
    input  logic [XLEN-1:0] imm_off,
    input  logic            use_imm,
    input  acc_size_e       size,
    output logic [XLEN-1:0] eff_addr,
    output logic            misaligned
);

    logic [XLEN-1:0] offset;

    // Choose the offset source and add it to the base.
    always_comb begin
        offset   = use_imm ? imm_off : offs_val;
        eff_addr = base_val + offset;
    end

    // An access must be aligned to its own size.
    always_comb begin
        case (size)
            SZ_WORD: misaligned = |eff_addr[1:0];
            SZ_HALF: misaligned = eff_addr[0];
            default: misaligned = 1'b0;
        endcase
    end

endmodule

// File: rtl/sized_load_extract.sv
// Selects and zero-extends the addressed lane of a little-endian word.
// Combinational. Assumes the address is already aligned to the size.
module sized_load_extract
    import sized_load_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] rdata,
    input  logic [1:0]      lane,
    input  acc_size_e       size,
    output logic [XLEN-1:0] value
);

    localparam int NBYTES = XLEN / 8;
    localparam int NHALVES = XLEN / 16;

    logic [7:0]  byte_lane [NBYTES];
    logic [15:0] half_lane [NHALVES];

    // Split the word into byte and halfword lanes.
    for (genvar b = 0; b < NBYTES; b++) begin : g_bytes
        assign byte_lane[b] = rdata[8*b +: 8];
    end
    for (genvar h = 0; h < NHALVES; h++) begin : g_halves
        assign half_lane[h] = rdata[16*h +: 16];
    end

    // Pick the lane for the access size and zero-extend it.
    always_comb begin
        case (size)
            SZ_BYTE: value = {{(XLEN-8){1'b0}}, byte_lane[lane]};
            SZ_HALF: value = {{(XLEN-16){1'b0}}, half_lane[lane[1]]};
            default: value = rdata;
        endcase
    end

endmodule

// File: rtl/sized_load_unit.sv
// Top of the sized load unit: decodes a load, forms its address,
// issues one word read and returns the zero-extended lane.
// Assumes one load in flight; starts while busy are dropped.
module sized_load_unit
    import sized_load_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] base_val,
    input  logic [XLEN-1:0] offs_val,
    output logic            mem_req,
    output logic [XLEN-1:0] mem_addr,
    input  logic            mem_valid,
    input  logic            mem_err,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] result,
    output logic            fault
);

    ld_ctrl_t        ctrl;
    logic [XLEN-1:0] imm_off;
    logic [XLEN-1:0] eff_addr;
    logic            misaligned;
    logic [XLEN-1:0] lane_value;

    ld_state_e       state;
    logic [XLEN-1:0] addr_q;
    acc_size_e       size_q;
    logic            done_q;
    logic            fault_q;
    logic [XLEN-1:0] result_q;

    logic            unused_fields;
    assign unused_fields = ^instr[20:11];

    sized_load_decode #(.XLEN(XLEN)) u_decode (
        .opcode  (instr[OP_W-1:0]),
        .imm_hi  (instr[31:21]),
        .imm_lo  (instr[10:7]),
        .ctrl    (ctrl),
        .imm_off (imm_off)
    );

    sized_load_agen #(.XLEN(XLEN)) u_agen (
        .base_val   (base_val),
        .offs_val   (offs_val),
        .imm_off    (imm_off),
        .use_imm    (ctrl.use_imm),
        .size       (ctrl.size),
        .eff_addr   (eff_addr),
        .misaligned (misaligned)
    );

    sized_load_extract #(.XLEN(XLEN)) u_extract (
        .rdata (mem_rdata),
        .lane  (addr_q[1:0]),
        .size  (size_q),
        .value (lane_value)
    );

    // Sequence a load: accept, request, wait for the response, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            addr_q   <= '0;
            size_q   <= SZ_WORD;
            done_q   <= 1'b0;
            fault_q  <= 1'b0;
            result_q <= '0;
        end else begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start && ctrl.legal) begin
                        if (misaligned) begin
                            fault_q <= 1'b1;
                        end else begin
                            addr_q <= eff_addr;
                            size_q <= ctrl.size;
                            state  <= ST_REQ;
                        end
                    end
                end
                ST_REQ, ST_WAIT: begin
                    if (mem_valid) begin
                        state <= ST_IDLE;
                        if (mem_err) begin
                            fault_q <= 1'b1;
                        end else begin
                            done_q   <= 1'b1;
                            result_q <= lane_value;
                        end
                    end else begin
                        state <= ST_WAIT;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the outputs from the registered state.
    always_comb begin
        mem_req  = (state == ST_REQ);
        mem_addr = addr_q;
        busy     = (state != ST_IDLE);
        done     = done_q;
        fault    = fault_q;
        result   = result_q;
    end

endmodule

// File: rtl/sized_load_unit_chk.sv
// Protocol checker for the sized load unit, attached by bind.
// Observes ports only; assumes synchronous active-low reset.
module sized_load_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mem_req,
    input logic [XLEN-1:0] mem_addr,
    input logic            mem_valid,
    input logic            mem_err,
    input logic            busy,
    input logic            done,
    input logic            fault
);

    a_r4_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    a_r4_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_addr));

    a_r8_done_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_valid && !mem_err));

    a_r8_valid_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_valid && !mem_err) |=> (done && !busy));

    a_r9_err_gives_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_valid && mem_err) |=> (fault && !done));

    a_r10_fault_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!mem_req && !done));

    a_r11_stay_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_valid) |=> busy);

    a_r12_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!mem_req && !busy && !done && !fault));

endmodule

bind sized_load_unit sized_load_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_valid (mem_valid),
    .mem_err   (mem_err),
    .busy      (busy),
    .done      (done),
    .fault     (fault)
);

// File: tb/sized_load_unit_test.sv
`timescale 1ns/1ps
module sized_load_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] base_val = '0;
    logic [31:0] offs_val = '0;
    logic        mem_valid = 1'b0;
    logic        mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_req, busy, done, fault;
    logic [31:0] mem_addr, result;

    int checks = 0;
    int fails = 0;
    bit reported = 0;

    always #2.5 clk = ~clk;

    sized_load_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .base_val(base_val), .offs_val(offs_val),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
        .mem_err(mem_err), .mem_rdata(mem_rdata), .busy(busy),
        .done(done), .result(result), .fault(fault)
    );

    typedef struct packed {
        logic [6:0]  op;
        logic [14:0] imm;
        logic        junk;
        logic [31:0] base;
        logic [31:0] offs;
        logic [31:0] rdata;
        logic [31:0] addr;
        logic [31:0] res;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{7'h01, 15'h0003, 1'b0, 32'h0000_1000, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'h0000_100C, 32'hDEAD_BEEF},
        '{7'h01, 15'h7FFF, 1'b0, 32'h0000_2000, 32'h0000_0100, 32'h1234_5678, 32'h0000_1FFC, 32'h1234_5678},
        '{7'h01, 15'h4000, 1'b0, 32'h0002_0000, 32'h0000_0000, 32'hA5A5_5A5A, 32'h0001_0000, 32'hA5A5_5A5A},
        '{7'h02, 15'h0005, 1'b0, 32'h0000_0100, 32'hFFFF_FFFF, 32'hCAFE_1234, 32'h0000_010A, 32'h0000_CAFE},
        '{7'h02, 15'h7FFE, 1'b0, 32'h0000_0108, 32'h0000_0000, 32'hCAFE_1234, 32'h0000_0104, 32'h0000_1234},
        '{7'h03, 15'h3FFF, 1'b0, 32'h0000_0000, 32'hFFFF_FFFF, 32'h1122_3344, 32'h0000_3FFF, 32'h0000_0011},
        '{7'h03, 15'h7FFF, 1'b0, 32'h0000_0041, 32'h0000_0007, 32'h1122_3344, 32'h0000_0040, 32'h0000_0044},
        '{7'h06, 15'h0000, 1'b0, 32'h0000_0200, 32'h0000_0001, 32'h1122_3344, 32'h0000_0201, 32'h0000_0033},
        '{7'h06, 15'h0000, 1'b1, 32'h0000_0300, 32'h0000_0002, 32'h1122_3344, 32'h0000_0302, 32'h0000_0022},
        '{7'h05, 15'h0000, 1'b0, 32'h0000_1000, 32'hFFFF_FFFE, 32'h8001_7FFF, 32'h0000_0FFE, 32'h0000_8001},
        '{7'h04, 15'h0000, 1'b1, 32'h0000_4000, 32'h0000_0010, 32'hFFFF_FFFF, 32'h0000_4010, 32'hFFFF_FFFF}
    };

    function automatic logic [31:0] mk_instr(logic [6:0] op, logic [14:0] imm, logic junk);
        logic [31:0] w;
        if (op >= 7'h04)
            w = {(junk ? 6'h3F : 6'h00), 5'd3, 5'd2, 5'd1, (junk ? 4'hF : 4'h0), op};
        else
            w = {imm[14:4], 5'd2, 5'd1, imm[3:0], op};
        return w;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        end
    endtask

    // Issue one load, answer after lat cycles, check request and response.
    task automatic run_load(string req, logic [31:0] iw, logic [31:0] b, logic [31:0] o,
                            logic [31:0] rd, logic err, int lat,
                            logic [31:0] exp_addr, logic [31:0] exp_res);
        @(negedge clk);
        instr = iw; base_val = b; offs_val = o; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({req, " R4 req"}, {31'd0, mem_req}, 32'd1);
        check({req, " R4 addr"}, mem_addr, exp_addr);
        for (int k = 0; k < lat; k++) begin
            @(negedge clk);
            check({req, " R4 req single"}, {31'd0, mem_req}, 32'd0);
        end
        mem_valid = 1'b1; mem_err = err; mem_rdata = rd;
        @(negedge clk);
        mem_valid = 1'b0; mem_err = 1'b0; mem_rdata = 32'h5555_AAAA;
        if (err) begin
            check({req, " R9 fault"}, {31'd0, fault}, 32'd1);
            check({req, " R9 no done"}, {31'd0, done}, 32'd0);
        end else begin
            check({req, " R8 done"}, {31'd0, done}, 32'd1);
            check({req, " R8 result"}, result, exp_res);
        end
        @(negedge clk);
        check({req, " R8 pulse ends"}, {30'd0, done, fault}, 32'd0);
        if (!err) check({req, " R8 result held"}, result, exp_res);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R12 reset", {28'd0, mem_req, busy, done, fault}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 after reset", {28'd0, mem_req, busy, done, fault}, 32'd0);

        // Table of R1/R2/R3/R5/R6/R7 vectors.
        for (int i = 0; i < NV; i++) begin
            run_load($sformatf("R1 R2 R3 R5 R6 R7 vec%0d", i),
                     mk_instr(VECS[i].op, VECS[i].imm, VECS[i].junk),
                     VECS[i].base, VECS[i].offs, VECS[i].rdata, 1'b0, i % 3,
                     VECS[i].addr, VECS[i].res);
        end

        // R9: error response.
        run_load("R9 error", mk_instr(7'h04, 15'h0, 1'b0), 32'h0000_0800, 32'h4,
                 32'h0, 1'b1, 1, 32'h0000_0804, 32'h0);

        // R10: misaligned word and halfword.
        @(negedge clk);
        instr = mk_instr(7'h04, 15'h0, 1'b0); base_val = 32'h1002; offs_val = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 word fault", {31'd0, fault}, 32'd1);
        check("R10 word no req", {30'd0, mem_req, busy}, 32'd0);
        @(negedge clk);
        instr = mk_instr(7'h02, 15'h0, 1'b0); base_val = 32'h1001; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 half fault", {31'd0, fault}, 32'd1);
        check("R10 half no req", {30'd0, mem_req, busy}, 32'd0);
        @(negedge clk);
        check("R10 fault pulse ends", {31'd0, fault}, 32'd0);

        // R11: unknown opcode ignored.
        instr = mk_instr(7'h0E, 15'h0, 1'b0); base_val = 32'h7000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R11 bad op no req", {30'd0, mem_req, busy}, 32'd0);
        @(negedge clk);
        check("R11 bad op quiet", {30'd0, done, fault}, 32'd0);

        // R11: start while busy is dropped.
        instr = mk_instr(7'h04, 15'h0, 1'b0); base_val = 32'h500; offs_val = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R4 busy load addr", mem_addr, 32'h500);
        @(negedge clk);
        base_val = 32'h600; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R11 addr kept", mem_addr, 32'h500);
        check("R11 no second req", {31'd0, mem_req}, 32'd0);
        mem_valid = 1'b1; mem_rdata = 32'h0BAD_F00D;
        @(negedge clk);
        mem_valid = 1'b0;
        check("R11 first load done", result, 32'h0BAD_F00D);
        @(negedge clk);
        check("R11 dropped start idle", {30'd0, mem_req, busy}, 32'd0);

        // R12: reset in flight clears everything.
        instr = mk_instr(7'h01, 15'h1, 1'b0); base_val = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check("R12 reset mid load", {28'd0, mem_req, busy, done, fault}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        report();
        $finish;
    end

endmodule